// File: doc/BRIEF.md
# Receive Frame Word FIFO

This block is the receive store of a bus controller. Complete frames arrive one 32-bit word per cycle on a write side, with a marker on the first word. Each frame is kept in a circular byte-addressed buffer as a run of whole words. A host reads the buffer through a single data port, and each read strobe removes one word. The first word of every frame carries a word-count field. The block uses that field twice: on the write side to decide whether the frame fits, and on the read side to find where the frame ends.

A frame that does not fit in the free space is dropped in full, so the host never sees part of a frame. The drop sets a sticky overrun flag and a one-cycle overrun interrupt. For each frame that is stored, the block raises a one-cycle receive interrupt and advances a running frame counter. The host can see the read and write byte pointers, the free space and the total size in words, the number of complete frames held, and empty and full flags. Command strobes flush the buffer, clear the overrun flag and zero the frame counter.

Top module: `rx_frame_fifo`

## Requirements
- R1: The header word's count field sits in bits [15:11]. A frame is that value plus one words long, and the block keeps exactly that many words of it. When a frame is accepted, free_words goes down by that many words, and frame_count goes up by one on the edge that takes the last word.
- R2: While bytes are stored, rd_data shows the word at rd_ptr. A read strobe moves rd_ptr forward by 4, modulo the capacity, and free_words goes up by one.
- R3: The count field of the first word popped from a frame sets that frame's length. frame_count drops by one only on the pop of that frame's last word.
- R4: empty is high exactly when frame_count is zero. It falls only together with a receive interrupt.
- R5: When no bytes are stored, rd_data is zero and a read strobe changes neither rd_ptr nor free_words.
- R6: If the stored bytes plus the incoming frame's bytes exceed the capacity, no word of that frame is kept. overrun is set and holds until it is cleared, irq_overrun pulses for one cycle, and the pointers and the frame count stay as they were.
- R7: On each stored frame, rx_frames goes up by one and irq_rx is high for the one cycle after the last word is taken.
- R8: wr_ptr equals (rd_ptr + stored bytes) modulo the capacity. free_words is (capacity − stored bytes)/4, and size_words is capacity/4.
- R9: full is high exactly when the stored bytes equal the capacity, and free_words is then zero.
- R10: cmd_flush sets rd_ptr, wr_ptr and frame_count to zero and frees all space. It does not change overrun or rx_frames.
- R11: cmd_clr_overrun clears overrun, and cmd_clr_count sets rx_frames to zero.
- R12: While ctrl_enable is low, a frame-start word is ignored and starts neither a store nor an overrun. A non-start word that has no accepted frame start before it is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_enable | input | 1 | Controller enable; frames are admitted only while high |
| cmd_flush | input | 1 | Empty the buffer |
| cmd_clr_overrun | input | 1 | Clear the sticky overrun flag |
| cmd_clr_count | input | 1 | Zero the received-frame counter |
| wr_valid | input | 1 | Incoming frame word valid |
| wr_first | input | 1 | Marks the header word of a frame |
| wr_data | input | 32 | Incoming frame word |
| rd_pop | input | 1 | Read strobe for the data port |
| rd_data | output | 32 | Word at the read pointer, zero when nothing is stored |
| rd_ptr | output | PTR_W | Read byte pointer |
| wr_ptr | output | PTR_W | Write byte pointer |
| free_words | output | CNT_W | Free space in words |
| size_words | output | CNT_W | Capacity in words |
| frame_count | output | CNT_W | Complete frames held |
| empty | output | 1 | No complete frame held |
| full | output | 1 | Stored bytes equal capacity |
| overrun | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | One-cycle pulse per stored frame |
| irq_overrun | output | 1 | One-cycle pulse per dropped frame |
| rx_frames | output | CTR_W | Running count of stored frames |

## Verification
The bench uses a 64-byte buffer. It writes one frame of every length from one to sixteen words and reads it back word by word. Because the read pointer wraps at different offsets along the way, this run shows whether the pointer arithmetic and the header-driven end-of-frame detection hold for every length, including a frame that fills the buffer exactly. Back-to-back frames of unequal length show whether the count drops at the right boundary and not at a word-count boundary. Frames that are too long, frames sent to a full buffer, frames sent with the controller disabled and stray continuation words show apart the three ways a frame can fail to land: overrun, disable and no start marker. An accepted frame written afterwards checks that nothing stray reached memory.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W        = 32;
    localparam int WORD_BYTES    = DATA_W / 8;
    localparam int WCNT_LSB      = 11;
    localparam int WCNT_W        = 5;
    localparam int FRAME_BYTES_W = WCNT_W + 3;

    typedef logic [DATA_W-1:0]        word_t;
    typedef logic [WCNT_W-1:0]        wcnt_t;
    typedef logic [FRAME_BYTES_W-1:0] fbytes_t;

    // write-side events produced for one cycle
    typedef struct packed {
        logic we;
        logic commit;
        logic reject;
    } ing_evt_t;

    function automatic wcnt_t hdr_wcnt(word_t w);
        return w[WCNT_LSB +: WCNT_W];
    endfunction

    // total frame size in bytes from the header count field
    function automatic fbytes_t frame_bytes(wcnt_t c);
        return (fbytes_t'(c) + fbytes_t'(1)) << 2;
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_ingress.sv
module rxf_ingress
    import rxf_pkg::*;
#(
    parameter int CAP_BYTES = 8192,
    parameter int PTR_W     = 13,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             enable,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  word_t            wr_data,
    input  logic [CNT_W-1:0] stored,
    input  logic [PTR_W-1:0] head,
    output ing_evt_t         evt,
    output logic [PTR_W-3:0] waddr,
    output fbytes_t          commit_bytes
);
    localparam int SUM_W = ((CNT_W > FRAME_BYTES_W) ? CNT_W : FRAME_BYTES_W) + 1;

    logic    active_q;
    wcnt_t   left_q;
    fbytes_t offset_q;
    fbytes_t size_q;

    wcnt_t            in_cnt;
    fbytes_t          need;
    logic             fits, start, cont, acc;
    logic [PTR_W-1:0] wbyte;

    always_comb begin
        in_cnt = hdr_wcnt(wr_data);
        need   = frame_bytes(in_cnt);
        fits   = (SUM_W'(stored) + SUM_W'(need)) <= SUM_W'(CAP_BYTES);
        start  = wr_valid && wr_first && enable && !flush;
        cont   = wr_valid && !wr_first && active_q && !flush;
        acc    = start && fits;
        evt.we     = acc || cont;
        evt.reject = start && !fits;
        evt.commit = (acc && in_cnt == '0) || (cont && left_q == wcnt_t'(1));
        commit_bytes = acc ? need : size_q;
        wbyte = head + (acc ? '0 : PTR_W'(offset_q));
        waddr = wbyte[PTR_W-1:2];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            active_q <= 1'b0;
            left_q   <= '0;
            offset_q <= '0;
            size_q   <= '0;
        end else if (start) begin
            active_q <= fits && (in_cnt != '0);
            left_q   <= in_cnt;
            offset_q <= fbytes_t'(WORD_BYTES);
            size_q   <= need;
        end else if (cont) begin
            left_q   <= left_q - wcnt_t'(1);
            offset_q <= offset_q + fbytes_t'(WORD_BYTES);
            if (left_q == wcnt_t'(1)) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_egress.sv
module rxf_egress
    import rxf_pkg::*;
#(
    parameter int PTR_W = 13,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             pop,
    input  logic [CNT_W-1:0] stored,
    input  word_t            mem_rdata,
    output logic [PTR_W-1:0] rd_ptr,
    output word_t            rd_data,
    output logic             pop_ok,
    output logic             frame_done
);
    fbytes_t rem_q;
    fbytes_t rem_cur;
    logic    has_data;

    always_comb begin
        has_data   = stored != '0;
        pop_ok     = pop && has_data && !flush;
        rd_data    = has_data ? mem_rdata : '0;
        rem_cur    = (rem_q == '0) ? frame_bytes(hdr_wcnt(mem_rdata)) : rem_q;
        frame_done = pop_ok && (rem_cur == fbytes_t'(WORD_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            rem_q  <= '0;
        end else if (pop_ok) begin
            rd_ptr <= rd_ptr + PTR_W'(WORD_BYTES);
            rem_q  <= rem_cur - fbytes_t'(WORD_BYTES);
        end
    end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
    import rxf_pkg::*;
#(
    parameter int  CAP_BYTES = 8192,
    parameter int  CTR_W     = 16,
    localparam int PTR_W     = $clog2(CAP_BYTES),
    localparam int CNT_W     = PTR_W + 1,
    localparam int AW        = PTR_W - 2,
    localparam int DEPTH     = CAP_BYTES / WORD_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_enable,
    input  logic             cmd_flush,
    input  logic             cmd_clr_overrun,
    input  logic             cmd_clr_count,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic [31:0]      wr_data,
    input  logic             rd_pop,
    output logic [31:0]      rd_data,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] free_words,
    output logic [CNT_W-1:0] size_words,
    output logic [CNT_W-1:0] frame_count,
    output logic             empty,
    output logic             full,
    output logic             overrun,
    output logic             irq_rx,
    output logic             irq_overrun,
    output logic [CTR_W-1:0] rx_frames
);
    logic [CNT_W-1:0] stored_q;
    logic [CNT_W-1:0] frames_q;
    ing_evt_t         evt;
    logic [AW-1:0]    waddr;
    fbytes_t          commit_bytes;
    word_t            mem_rdata;
    logic             pop_ok, frame_done;

    rxf_ingress #(.CAP_BYTES(CAP_BYTES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ing (
        .clk(clk), .rst(rst), .flush(cmd_flush), .enable(ctrl_enable),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_data(wr_data),
        .stored(stored_q), .head(wr_ptr), .evt(evt), .waddr(waddr),
        .commit_bytes(commit_bytes)
    );

    rxf_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(evt.we), .waddr(waddr), .wdata(wr_data),
        .raddr(rd_ptr[PTR_W-1:2]), .rdata(mem_rdata)
    );

    rxf_egress #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_egr (
        .clk(clk), .rst(rst), .flush(cmd_flush), .pop(rd_pop),
        .stored(stored_q), .mem_rdata(mem_rdata), .rd_ptr(rd_ptr),
        .rd_data(rd_data), .pop_ok(pop_ok), .frame_done(frame_done)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd_flush) begin
            stored_q <= '0;
            frames_q <= '0;
        end else begin
            stored_q <= stored_q
                      - (pop_ok ? CNT_W'(WORD_BYTES) : '0)
                      + (evt.commit ? CNT_W'(commit_bytes) : '0);
            frames_q <= frames_q
                      - (frame_done ? CNT_W'(1) : '0)
                      + (evt.commit ? CNT_W'(1) : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun     <= 1'b0;
            irq_rx      <= 1'b0;
            irq_overrun <= 1'b0;
            rx_frames   <= '0;
        end else begin
            irq_rx      <= evt.commit;
            irq_overrun <= evt.reject;
            if (evt.reject)           overrun <= 1'b1;
            else if (cmd_clr_overrun) overrun <= 1'b0;
            if (cmd_clr_count)        rx_frames <= '0;
            else if (evt.commit)      rx_frames <= rx_frames + CTR_W'(1);
        end
    end

    assign wr_ptr      = rd_ptr + stored_q[PTR_W-1:0];
    assign free_words  = (CNT_W'(CAP_BYTES) - stored_q) >> 2;
    assign size_words  = CNT_W'(DEPTH);
    assign frame_count = frames_q;
    assign empty       = frames_q == '0;
    assign full        = stored_q == CNT_W'(CAP_BYTES);
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int  CAP_BYTES = 8192,
    parameter int  CTR_W     = 16,
    localparam int PTR_W     = $clog2(CAP_BYTES),
    localparam int CNT_W     = PTR_W + 1,
    localparam int DEPTH     = CAP_BYTES / 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ctrl_enable,
    input logic             cmd_flush,
    input logic             cmd_clr_overrun,
    input logic             cmd_clr_count,
    input logic             wr_valid,
    input logic             wr_first,
    input logic             rd_pop,
    input logic [31:0]      rd_data,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [CNT_W-1:0] free_words,
    input logic [CNT_W-1:0] frame_count,
    input logic             empty,
    input logic             full,
    input logic             overrun,
    input logic             irq_rx,
    input logic             irq_overrun,
    input logic [CTR_W-1:0] rx_frames
);
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && free_words != CNT_W'(DEPTH) && !cmd_flush)
        |=> rd_ptr == $past(rd_ptr) + PTR_W'(4));

    a_r3_drop_needs_pop: assert property (@(posedge clk) disable iff (rst)
        (frame_count < $past(frame_count)) |-> ($past(rd_pop) || $past(cmd_flush)));

    a_r4_empty_falls_on_rx: assert property (@(posedge clk) disable iff (rst)
        $fell(empty) |-> irq_rx);

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && free_words == CNT_W'(DEPTH)) |-> rd_data == '0);

    a_r5_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && free_words == CNT_W'(DEPTH) && !cmd_flush) |=> $stable(rd_ptr));

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !cmd_clr_overrun) |=> overrun);

    a_r6_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
        irq_overrun |-> overrun);

    a_r7_counter_step: assert property (@(posedge clk) disable iff (rst)
        (irq_rx && !$past(cmd_clr_count)) |-> rx_frames == $past(rx_frames) + CTR_W'(1));

    a_r8_ptr_gap: assert property (@(posedge clk) disable iff (rst)
        !full |-> (CNT_W'(PTR_W'(wr_ptr - rd_ptr)) + (free_words << 2)) == CNT_W'(CAP_BYTES));

    a_r9_full_no_free: assert property (@(posedge clk) disable iff (rst)
        full |-> free_words == '0);

    a_r10_flush: assert property (@(posedge clk) disable iff (rst)
        cmd_flush |=> (frame_count == '0 && rd_ptr == '0 && wr_ptr == '0
                       && free_words == CNT_W'(DEPTH)));

    a_r12_disabled_start: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_first && !ctrl_enable) |=> !irq_overrun);
endmodule

bind rx_frame_fifo rxf_checker #(.CAP_BYTES(CAP_BYTES), .CTR_W(CTR_W)) u_chk (
    .clk(clk), .rst(rst), .ctrl_enable(ctrl_enable), .cmd_flush(cmd_flush),
    .cmd_clr_overrun(cmd_clr_overrun), .cmd_clr_count(cmd_clr_count),
    .wr_valid(wr_valid), .wr_first(wr_first), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .free_words(free_words), .frame_count(frame_count), .empty(empty),
    .full(full), .overrun(overrun), .irq_rx(irq_rx),
    .irq_overrun(irq_overrun), .rx_frames(rx_frames)
);

// File: tb/tb_rx_frame_fifo.sv
`timescale 1ns/1ps
module tb_rx_frame_fifo;
    localparam int CAP   = 64;
    localparam int WORDS = CAP / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_enable = 1'b0;
    logic        cmd_flush = 1'b0, cmd_clr_overrun = 1'b0, cmd_clr_count = 1'b0;
    logic        wr_valid = 1'b0, wr_first = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic [5:0]  rd_ptr, wr_ptr;
    logic [6:0]  free_words, size_words, frame_count;
    logic        empty, full, overrun, irq_rx, irq_overrun;
    logic [15:0] rx_frames;

    rx_frame_fifo #(.CAP_BYTES(CAP), .CTR_W(16)) dut (
        .clk(clk), .rst(rst), .ctrl_enable(ctrl_enable), .cmd_flush(cmd_flush),
        .cmd_clr_overrun(cmd_clr_overrun), .cmd_clr_count(cmd_clr_count),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_data(wr_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .free_words(free_words), .size_words(size_words),
        .frame_count(frame_count), .empty(empty), .full(full),
        .overrun(overrun), .irq_rx(irq_rx), .irq_overrun(irq_overrun),
        .rx_frames(rx_frames)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_rd = 0;
    int exp_words = 0;
    int exp_ctr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] word_of(int wcnt, int seed, int k);
        if (k == 0) return {seed[7:0], 8'h00, wcnt[4:0], 11'h000};
        return {seed[7:0], k[7:0], 16'h5A5A};
    endfunction

    task automatic write_frame(input int wcnt, input int seed,
                               output bit saw_rx, output bit saw_ovr);
        saw_rx = 0;
        saw_ovr = 0;
        for (int k = 0; k <= wcnt; k++) begin
            wr_valid = 1'b1;
            wr_first = (k == 0);
            wr_data  = word_of(wcnt, seed, k);
            tick();
            if (irq_rx) saw_rx = 1;
            if (irq_overrun) saw_ovr = 1;
        end
        wr_valid = 1'b0;
        wr_first = 1'b0;
    endtask

    task automatic pop_word(input logic [31:0] expv, input string req);
        chk(rd_data == expv, req, "rd_data", rd_data, expv);
        rd_pop = 1'b1;
        tick();
        rd_pop = 1'b0;
        exp_rd = (exp_rd + 4) % CAP;
        exp_words--;
        chk(rd_ptr == exp_rd, "R2", "rd_ptr after pop", rd_ptr, exp_rd);
    endtask

    task automatic do_flush();
        cmd_flush = 1'b1;
        tick();
        cmd_flush = 1'b0;
        exp_rd = 0;
        exp_words = 0;
    endtask

    initial begin
        bit rx, ov;
        repeat (3) tick();
        rst = 1'b0;
        ctrl_enable = 1'b1;
        tick();
        // reset state
        chk(empty == 1'b1, "R4", "reset empty", empty, 1);
        chk(free_words == WORDS, "R8", "reset free_words", free_words, WORDS);
        chk(size_words == WORDS, "R8", "size_words", size_words, WORDS);
        chk(rd_ptr == 0 && wr_ptr == 0, "R8", "reset pointers", rd_ptr, 0);
        chk(!overrun && !full && rx_frames == 0, "R6", "reset flags", overrun, 0);

        // R5: read with nothing stored
        chk(rd_data == 0, "R5", "empty rd_data", rd_data, 0);
        rd_pop = 1'b1; tick(); rd_pop = 1'b0;
        chk(rd_ptr == 0, "R5", "rd_ptr after empty pop", rd_ptr, 0);
        chk(free_words == WORDS, "R5", "free after empty pop", free_words, WORDS);

        // sweep every frame length that fits
        for (int w = 0; w < WORDS; w++) begin
            write_frame(w, w + 1, rx, ov);
            exp_words += w + 1;
            exp_ctr++;
            chk(rx && !ov, "R7", "irq_rx pulse on store", rx, 1);
            chk(rx_frames == exp_ctr, "R7", "rx_frames", rx_frames, exp_ctr);
            chk(frame_count == 1, "R1", "frame_count after store", frame_count, 1);
            chk(free_words == WORDS - (w + 1), "R1", "free after store", free_words, WORDS - (w + 1));
            chk(wr_ptr == (exp_rd + 4 * (w + 1)) % CAP, "R8", "wr_ptr", wr_ptr, (exp_rd + 4 * (w + 1)) % CAP);
            chk(full == (w == WORDS - 1), "R9", "full flag", full, (w == WORDS - 1));
            chk(empty == 1'b0, "R4", "not empty after store", empty, 0);
            for (int k = 0; k <= w; k++) begin
                chk(frame_count == 1, "R3", "frame_count mid frame", frame_count, 1);
                pop_word(word_of(w, w + 1, k), "R2");
                chk(free_words == WORDS - exp_words, "R2", "free after pop", free_words, WORDS - exp_words);
            end
            chk(frame_count == 0 && empty, "R3", "frame_count at end", frame_count, 0);
        end

        // two frames of unequal length
        write_frame(2, 8'h40, rx, ov); exp_words += 3; exp_ctr++;
        write_frame(1, 8'h41, rx, ov); exp_words += 2; exp_ctr++;
        chk(frame_count == 2, "R3", "two frames held", frame_count, 2);
        pop_word(word_of(2, 8'h40, 0), "R3");
        pop_word(word_of(2, 8'h40, 1), "R3");
        chk(frame_count == 2, "R3", "count before boundary", frame_count, 2);
        pop_word(word_of(2, 8'h40, 2), "R3");
        chk(frame_count == 1, "R3", "count after first frame", frame_count, 1);
        pop_word(word_of(1, 8'h41, 0), "R3");
        pop_word(word_of(1, 8'h41, 1), "R3");
        chk(frame_count == 0, "R3", "count after second frame", frame_count, 0);

        // R6: frame too long for an empty buffer
        begin
            int rp;
            rp = exp_rd;
            write_frame(WORDS, 8'h50, rx, ov);
            chk(ov && !rx, "R6", "overrun pulse only", ov, 1);
            chk(overrun == 1'b1, "R6", "overrun flag", overrun, 1);
            chk(free_words == WORDS && frame_count == 0, "R6", "nothing stored", free_words, WORDS);
            chk(rd_ptr == rp && wr_ptr == rp, "R6", "pointers unchanged", wr_ptr, rp);
            repeat (3) tick();
            chk(overrun == 1'b1 && irq_overrun == 1'b0, "R6", "sticky flag, single pulse", overrun, 1);
        end
        cmd_clr_overrun = 1'b1; tick(); cmd_clr_overrun = 1'b0;
        chk(overrun == 1'b0, "R11", "overrun cleared", overrun, 0);

        // R9: fill exactly, then reject
        do_flush();
        for (int f = 0; f < 4; f++) begin
            write_frame(3, 8'h60 + f, rx, ov);
            exp_words += 4; exp_ctr++;
        end
        chk(full == 1'b1 && free_words == 0, "R9", "full after four frames", full, 1);
        write_frame(0, 8'h70, rx, ov);
        chk(ov && frame_count == 4, "R6", "reject when full", frame_count, 4);
        for (int k = 0; k < 4; k++) pop_word(word_of(3, 8'h60, k), "R9");
        chk(frame_count == 3 && full == 1'b0, "R9", "not full after pop", full, 0);
        write_frame(0, 8'h71, rx, ov); exp_words += 1; exp_ctr++;
        chk(rx && frame_count == 4 && free_words == 3, "R1", "fit after pop", free_words, 3);

        // R10: flush
        do_flush();
        chk(frame_count == 0 && empty, "R10", "flush frame_count", frame_count, 0);
        chk(rd_ptr == 0 && wr_ptr == 0, "R10", "flush pointers", wr_ptr, 0);
        chk(free_words == WORDS, "R10", "flush free", free_words, WORDS);
        chk(overrun == 1'b1, "R10", "flush keeps overrun", overrun, 1);
        chk(rx_frames == exp_ctr, "R10", "flush keeps counter", rx_frames, exp_ctr);
        cmd_clr_overrun = 1'b1; tick(); cmd_clr_overrun = 1'b0;
        chk(overrun == 1'b0, "R11", "overrun cleared again", overrun, 0);

        // R12: disabled controller and stray words
        ctrl_enable = 1'b0;
        write_frame(1, 8'h80, rx, ov);
        chk(!rx && free_words == WORDS && frame_count == 0, "R12", "disabled frame ignored", free_words, WORDS);
        write_frame(20, 8'h81, rx, ov);
        chk(!ov && overrun == 1'b0, "R12", "disabled no overrun", overrun, 0);
        ctrl_enable = 1'b1;
        wr_valid = 1'b1; wr_first = 1'b0; wr_data = 32'hDEAD_BEEF;
        tick();
        wr_valid = 1'b0;
        chk(free_words == WORDS && rx_frames == exp_ctr, "R12", "stray word ignored", free_words, WORDS);
        write_frame(0, 8'h90, rx, ov); exp_words += 1; exp_ctr++;
        chk(rx && frame_count == 1, "R12", "enabled frame stored", frame_count, 1);
        pop_word(word_of(0, 8'h90, 0), "R12");

        // R11: counter clear
        chk(rx_frames == exp_ctr, "R7", "counter before clear", rx_frames, exp_ctr);
        cmd_clr_count = 1'b1; tick(); cmd_clr_count = 1'b0;
        chk(rx_frames == 0, "R11", "counter cleared", rx_frames, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule